// File: doc/BRIEF.md
# Character-Output Instruction Decoder

This block sits in the execute slot of a small five-stage integer pipeline. It recognises one custom instruction that prints a character, and turns it into a single byte plus a write strobe toward a video character memory. The operand comes from the pipeline's normal register path. The block takes the 32-bit instruction word, the forwarded value of the named source register and a valid flag. The valid flag is low whenever the pipeline has stalled or flushed the slot.

One mode field selects between two sources for the character. Two register modes print the upper or lower hex digit of the operand's low byte as ASCII. An immediate mode prints a character that is encoded in the instruction itself. Inside the immediate mode, some sub-codes stand for enter and backspace, and these produce no write. The source-register specifier is sent straight out so that the hazard and forwarding logic treats the instruction as a reader of that register.

Bit positions below use conventional numbering, so bit 31 is the most significant bit.

Top module: `chrout_dec`

## Requirements
- R1: An instruction is decoded only when instr[31:26] equals 6'b101100 and valid is high. Any other opcode produces wr_en low and char_o equal to 8'h00 one cycle later.
- R2: src_reg always equals instr[20:16], combinationally, whatever the values of valid and the opcode.
- R3: The output mode is instr[22:21]. The bits instr[25:23] and instr[15:8] have no effect on either output.
- R4: Mode 2'b00 writes the ASCII hex digit of operand[7:4].
- R5: Mode 2'b01 writes the ASCII hex digit of operand[3:0].
- R6: A hex digit n in the range 0–9 becomes 8'h30+n. A hex digit n in the range 10–15 becomes 8'h37+n, which gives the upper-case letters 8'h41–8'h46.
- R7: In mode 2'b10, when instr[7:6] equals 2'b00, the block writes the character {2'b00, instr[5:0]}.
- R8: In mode 2'b10, when instr[7:6] is 2'b01 (enter), 2'b10 (backspace) or 2'b11, wr_en stays low and char_o is 8'h00.
- R9: Mode 2'b11 never writes, and it drives char_o to 8'h00.
- R10: The outputs are registered with one cycle of latency. wr_en is high for exactly the one cycle that follows each valid, writing instruction, and is never high after a cycle with valid low. Whenever wr_en is low, char_o is 8'h00.
- R11: While rst is high at a clock edge, the next outputs are wr_en = 0 and char_o = 8'h00, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | The instruction in this slot is live (low when stalled or flushed) |
| instr | input | 32 | Instruction word |
| operand | input | 32 | Forwarded value of the source register |
| src_reg | output | 5 | Source-register specifier for the forwarding and hazard logic |
| wr_en | output | 1 | One-cycle write strobe toward the character memory |
| char_o | output | 8 | Character byte; zero whenever no write happens |

## Verification
The bound checker checks on every cycle that a strobe follows only a valid instruction with a matching opcode, and that an idle slot never produces one. It also checks that char_o is zero whenever no strobe is present, that every hex-mode byte lies in the ASCII hex set, that a strobe in immediate mode comes only from a printable sub-code, and that mode 2'b11 stays silent. Whether each byte is the exact one for a given digit or immediate, whether the reserved bits are truly ignored, and how the block behaves across a reset in the middle of activity can only be shown by the bench. The bench does this with full sweeps over the operand byte, the immediate byte, every opcode and the reserved mode bits.

// File: rtl/chrout_pkg.sv
package chrout_pkg;

    localparam int INSTR_W = 32;
    localparam int CHAR_W  = 8;
    localparam int REG_W   = 5;
    localparam int NIB_W   = 4;
    localparam int OPC_W   = 6;

    localparam logic [OPC_W-1:0] OPC_CHAR_OUT = 6'b101100;

    // Field positions, conventional numbering (bit 31 = MSB)
    localparam int OPC_LSB  = INSTR_W - OPC_W;   // 26
    localparam int MODE_LSB = 21;
    localparam int SRC_LSB  = 16;
    localparam int IMM_LSB  = 0;

    typedef enum logic [1:0] {
        MODE_HI_NIB = 2'b00,
        MODE_LO_NIB = 2'b01,
        MODE_IMM    = 2'b10,
        MODE_UNUSED = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        IMM_PRINT = 2'b00,
        IMM_ENTER = 2'b01,
        IMM_BKSP  = 2'b10,
        IMM_RSVD  = 2'b11
    } imm_kind_e;

    typedef struct packed {
        logic              hit;
        out_mode_e         mode;
        logic [REG_W-1:0]  src;
        logic [CHAR_W-1:0] imm;
    } chr_fields_t;

    typedef struct packed {
        logic              we;
        logic [CHAR_W-1:0] ch;
    } chr_req_t;

    localparam chr_req_t REQ_IDLE = '{we: 1'b0, ch: '0};

    function automatic logic [CHAR_W-1:0] hex_ascii(input logic [NIB_W-1:0] n);
        logic [CHAR_W-1:0] wide;
        wide = {{(CHAR_W-NIB_W){1'b0}}, n};
        if (n < 4'd10)
            return 8'h30 + wide;
        else
            return 8'h37 + wide;
    endfunction

endpackage

// File: rtl/chrout_field_split.sv
module chrout_field_split
    import chrout_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output chr_fields_t        fields
);
    logic unused_rsvd;

    always_comb begin
        fields.hit  = (instr[INSTR_W-1:OPC_LSB] == OPC_CHAR_OUT);
        fields.mode = out_mode_e'(instr[MODE_LSB +: 2]);
        fields.src  = instr[SRC_LSB +: REG_W];
        fields.imm  = instr[IMM_LSB +: CHAR_W];
    end

    // Reserved mode bits and the zero gap are intentionally not decoded
    assign unused_rsvd = ^{instr[OPC_LSB-1:MODE_LSB+2], instr[SRC_LSB-1:CHAR_W]};
endmodule

// File: rtl/chrout_char_sel.sv
module chrout_char_sel
    import chrout_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              valid,
    input  chr_fields_t       fields,
    input  logic [DATA_W-1:0] operand,
    output chr_req_t          req
);
    logic [CHAR_W-1:0] low_byte;
    imm_kind_e         kind;

    assign low_byte = operand[CHAR_W-1:0];
    assign kind     = imm_kind_e'(fields.imm[CHAR_W-1 -: 2]);

    generate
        if (DATA_W > CHAR_W) begin : g_wide
            logic unused_upper;
            assign unused_upper = ^operand[DATA_W-1:CHAR_W];
        end
    endgenerate

    always_comb begin
        req = REQ_IDLE;
        if (valid && fields.hit) begin
            unique case (fields.mode)
                MODE_HI_NIB: begin
                    req.we = 1'b1;
                    req.ch = hex_ascii(low_byte[CHAR_W-1 -: NIB_W]);
                end
                MODE_LO_NIB: begin
                    req.we = 1'b1;
                    req.ch = hex_ascii(low_byte[NIB_W-1:0]);
                end
                MODE_IMM: begin
                    if (kind == IMM_PRINT) begin
                        req.we = 1'b1;
                        req.ch = {2'b00, fields.imm[CHAR_W-3:0]};
                    end
                end
                MODE_UNUSED: req = REQ_IDLE;
                default:     req = REQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chrout_out_reg.sv
module chrout_out_reg
    import chrout_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  chr_req_t req_in,
    output chr_req_t req_out
);
    always_ff @(posedge clk) begin
        if (rst)
            req_out <= REQ_IDLE;
        else
            req_out <= req_in;
    end
endmodule

// File: rtl/chrout_dec.sv
module chrout_dec
    import chrout_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   operand,
    output logic [REG_W-1:0]    src_reg,
    output logic                wr_en,
    output logic [CHAR_W-1:0]   char_o
);
    chr_fields_t fields;
    chr_req_t    req_d;
    chr_req_t    req_q;

    chrout_field_split u_split (
        .instr  (instr),
        .fields (fields)
    );

    chrout_char_sel #(.DATA_W(DATA_W)) u_sel (
        .valid   (valid),
        .fields  (fields),
        .operand (operand),
        .req     (req_d)
    );

    chrout_out_reg u_oreg (
        .clk     (clk),
        .rst     (rst),
        .req_in  (req_d),
        .req_out (req_q)
    );

    assign src_reg = fields.src;
    assign wr_en   = req_q.we;
    assign char_o  = req_q.ch;
endmodule

// File: rtl/chrout_dec_chk.sv
module chrout_dec_chk
    import chrout_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid,
    input logic [OPC_W-1:0]  opc,
    input logic [1:0]        mode_lo,
    input logic [1:0]        imm_top,
    input logic              wr_en,
    input logic [CHAR_W-1:0] char_o
);
    AST_WE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(valid) && $past(opc) == OPC_CHAR_OUT)); // R1

    AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !valid |=> !wr_en); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (char_o == '0)); // R10

    AST_HEX_CHAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !$past(mode_lo[1])) |->
            ((char_o >= 8'h30 && char_o <= 8'h39) ||
             (char_o >= 8'h41 && char_o <= 8'h46))); // R6

    AST_IMM_PLAIN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(mode_lo) == 2'b10) |->
            ($past(imm_top) == 2'b00 && char_o[7:6] == 2'b00)); // R7

    AST_MODE3_QUIET: assert property (@(posedge clk) disable iff (rst)
        (valid && mode_lo == 2'b11) |=> !wr_en); // R9
endmodule

bind chrout_dec chrout_dec_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid   (valid),
    .opc     (instr[31:26]),
    .mode_lo (instr[22:21]),
    .imm_top (instr[7:6]),
    .wr_en   (wr_en),
    .char_o  (char_o)
);

// File: tb/chrout_dec_bench.sv
`timescale 1ns/1ps
module chrout_dec_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] operand = '0;
    logic [4:0]  src_reg;
    logic        wr_en;
    logic [7:0]  char_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    chrout_dec u_chrout_dec (
        .clk(clk), .rst(rst), .valid(valid), .instr(instr),
        .operand(operand), .src_reg(src_reg), .wr_en(wr_en), .char_o(char_o)
    );

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] mode,
                                       input logic [4:0] src, input logic [7:0] gap,
                                       input logic [7:0] imm);
        return {opc, mode, src, gap, imm};
    endfunction

    function automatic logic [7:0] digit(input int n);
        return (n < 10) ? 8'(48 + n) : 8'(55 + n);
    endfunction

    // Expected outputs derived from the requirement text
    task automatic expect_of(input logic [31:0] i, input logic [31:0] v, input logic vl,
                             output logic we, output logic [7:0] ch);
        int m;
        we = 1'b0; ch = 8'h00;
        m = int'(i[22:21]);
        if (vl && i[31:26] == 6'b101100) begin
            if (m == 0)      begin we = 1'b1; ch = digit(int'(v[7:4])); end
            else if (m == 1) begin we = 1'b1; ch = digit(int'(v[3:0])); end
            else if (m == 2 && i[7:6] == 2'b00) begin we = 1'b1; ch = {2'b00, i[5:0]}; end
        end
    endtask

    task automatic check(input string req, input logic we_a, input logic [7:0] ch_a,
                         input logic we_e, input logic [7:0] ch_e);
        n_chk++;
        if (we_a !== we_e || ch_a !== ch_e) begin
            n_bad++;
            $display("FAIL %s: actual we=%b ch=%h expected we=%b ch=%h",
                     req, we_a, ch_a, we_e, ch_e);
        end
    endtask

    task automatic run_vec(input string req, input logic [31:0] i,
                           input logic [31:0] v, input logic vl);
        logic we_e;
        logic [7:0] ch_e;
        expect_of(i, v, vl, we_e, ch_e);
        @(negedge clk);
        instr = i; operand = v; valid = vl;
        @(posedge clk);
        #1;
        check(req, wr_en, char_o, we_e, ch_e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R11", wr_en, char_o, 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R2: specifier passes straight through, valid high or low
        for (int r = 0; r < 32; r++) begin
            @(negedge clk);
            instr = mk(6'(r * 5), 5'(r), 5'(r), 8'hFF, 8'(r));
            valid = r[0];
            #1;
            n_chk++;
            if (src_reg !== 5'(r)) begin
                n_bad++;
                $display("FAIL R2: actual %0d expected %0d", src_reg, r);
            end
        end

        // R4, R5, R6: every operand byte in both hex modes, noisy upper bits
        for (int b = 0; b < 256; b++) begin
            run_vec("R4", mk(6'b101100, 5'b00000, 5'd3, 8'h00, 8'h00),
                    {24'hA55A3C, 8'(b)}, 1'b1);
            run_vec("R5", mk(6'b101100, 5'b00001, 5'd7, 8'h00, 8'hFF),
                    {24'h5AA5C3, 8'(b)}, 1'b1);
        end
        // R6: explicit boundary digits
        run_vec("R6", mk(6'b101100, 5'b00001, 5'd1, 8'h00, 8'h00), 32'h0000_0009, 1'b1);
        check("R6", wr_en, char_o, 1'b1, 8'h39);
        run_vec("R6", mk(6'b101100, 5'b00000, 5'd1, 8'h00, 8'h00), 32'h0000_00A0, 1'b1);
        check("R6", wr_en, char_o, 1'b1, 8'h41);

        // R7, R8: every immediate byte in immediate mode
        for (int b = 0; b < 256; b++)
            run_vec(b < 64 ? "R7" : "R8",
                    mk(6'b101100, 5'b00010, 5'd9, 8'h00, 8'(b)), 32'h0000_0031, 1'b1);

        // R9: mode 11 across immediates and operands
        for (int b = 0; b < 64; b++)
            run_vec("R9", mk(6'b101100, 5'b00011, 5'd2, 8'h00, 8'(b * 4)),
                    32'(b * 17), 1'b1);

        // R3: reserved mode bits and gap bits change nothing
        for (int h = 0; h < 8; h++)
            for (int m = 0; m < 4; m++)
                run_vec("R3", mk(6'b101100, {3'(h), 2'(m)}, 5'd4, 8'(h * 37), 8'h1B),
                        32'h0000_00E7, 1'b1);

        // R1: every other opcode stays silent
        for (int o = 0; o < 64; o++)
            if (o != 6'b101100)
                run_vec("R1", mk(6'(o), 5'b00010, 5'd5, 8'h00, 8'h21), 32'h0000_0042, 1'b1);

        // R10: valid low suppresses, strobe lasts one cycle only
        run_vec("R10", mk(6'b101100, 5'b00000, 5'd6, 8'h00, 8'h00), 32'h0000_00C0, 1'b0);
        run_vec("R10", mk(6'b101100, 5'b00010, 5'd6, 8'h00, 8'h25), 32'h0, 1'b1);
        run_vec("R10", mk(6'b101100, 5'b00010, 5'd6, 8'h00, 8'h25), 32'h0, 1'b0);
        @(posedge clk); #1;
        check("R10", wr_en, char_o, 1'b0, 8'h00);

        // R11: reset in the middle of activity
        @(negedge clk);
        instr = mk(6'b101100, 5'b00001, 5'd8, 8'h00, 8'h00);
        operand = 32'h0000_000F; valid = 1'b1; rst = 1'b1;
        @(posedge clk); #1;
        check("R11", wr_en, char_o, 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        run_vec("R11", mk(6'b101100, 5'b00001, 5'd8, 8'h00, 8'h00), 32'h0000_000F, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule